// File: doc/BRIEF.md
# Console Receive Register Interface

This block is the processor-facing receive side of a serial console. An external receiver delivers characters, or a line-break event, as single-cycle strobes. The block keeps one received character, together with its error flags, in a 16-bit data register. A control/status register holds a done flag and an interrupt-enable flag. A level interrupt request tells the processor that a character is waiting.

Software reaches both registers through a small port. `sel` picks the register (0 = status, 1 = data). `wr_en` writes the selected register. `rd_stb` reads it, and the value appears on `rd_data` one cycle later.

Reading the data register is destructive. In the same access it clears done, drops the interrupt request and removes the error flags from the stored value. A received break loads a fixed error pattern. When the halt-enable input is set, a break also pulses a halt request to the processor. A static mode input chooses 7-bit or 8-bit characters.

Top module: `rx_console_regs`

## Requirements
- R1: The status register reads with done in bit 7 and interrupt-enable in bit 6, and every other bit reads as zero. A status write changes only interrupt-enable, which it takes from `wr_data[6]`.
- R2: A data read returns the whole stored 16-bit value. The character is in bits 7:0, bit 15 is the summary error flag, bit 14 is overrun, bit 13 is framing error and bit 10 is break.
- R3: Each received character sets done. It raises `irq` only if interrupt-enable is set in that cycle.
- R4: A data read, in the same access, clears done, zeroes bits 15:8 of the stored value and deasserts `irq`.
- R5: A status write with bit 6 at 0 deasserts `irq` in the next cycle. A status write with bit 6 at 1 while done is set asserts `irq` in the next cycle.
- R6: A break event loads the data register with 0xA400, which sets bits 15, 13 and 10 and carries a zero character. It also sets done.
- R7: `halt_req` is high for exactly the one cycle after a break event that arrives while `halt_en` is 1. Otherwise it stays low.
- R8: With `mode8` at 0, a received character is stored masked to bits 6:0. With `mode8` at 1, all eight bits are kept.
- R9: A character that arrives while done is still set, with no data read in the same cycle, replaces the stored character and sets bits 15 and 14.
- R10: Reset clears both registers, `rd_data`, `irq` and `halt_req`.
- R11: Writes to the data register have no effect.
- R12: `rd_data` updates only in the cycle after `rd_stb`, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select: 0 status, 1 data |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_stb | input | 1 | Read strobe for the selected register |
| rd_data | output | 16 | Registered read data |
| rx_valid | input | 1 | One-cycle strobe: a character is present on rx_char |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | One-cycle strobe: line break detected |
| halt_en | input | 1 | Allows a break to request a halt |
| mode8 | input | 1 | 1 keeps 8-bit characters, 0 masks them to 7 bits |
| irq | output | 1 | Level interrupt request |
| halt_req | output | 1 | One-cycle halt request after an enabled break |

## Verification
The bench builds the block with its default 16-bit register and 8-bit character width. At that size every one of the 256 character codes can be pushed through in both character modes. Interrupt-enable alternates across the sweep, so the character masking, the done and interrupt behaviour and the destructive read are all checked for every code. Dedicated sequences then cover the remaining cases: overrun, break with halt enabled and disabled, enabling interrupts while done is already set, writes to the read-only data register and a reset taken with state pending.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic {
    REG_STAT = 1'b0,
    REG_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rxc_status.sv
module rxc_status #(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stat,
  input  logic wr_ie,
  input  logic rd_hit,
  input  logic rx_evt,
  output logic done_q,
  output logic ie_q,
  output logic irq_q
);
  logic done_n, ie_n, irq_n;

  // Order of effects in one cycle: status write, then data read, then receive.
  always_comb begin
    ie_n   = ie_q;
    done_n = done_q;
    irq_n  = irq_q;
    if (wr_stat) begin
      ie_n = wr_ie;
      if (!wr_ie)      irq_n = 1'b0;
      else if (done_q) irq_n = 1'b1;
    end
    if (rd_hit) begin
      done_n = 1'b0;
      irq_n  = 1'b0;
    end
    if (rx_evt) begin
      done_n = 1'b1;
      if (ie_n) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/rxc_buffer.sv
module rxc_buffer #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              mode8,
  input  logic              done_q,
  input  logic              rd_hit,
  output logic [DATA_W-1:0] buf_q
);
  localparam int ERR_BIT = DATA_W - 1;
  localparam int OVR_BIT = DATA_W - 2;
  localparam int FRM_BIT = DATA_W - 3;
  localparam int BRK_BIT = DATA_W - 6;
  localparam int FLG_W   = DATA_W - CHAR_W;

  logic [CHAR_W-1:0] char_mask;
  logic [CHAR_W-1:0] char_in;
  logic [DATA_W-1:0] brk_word;
  logic              overrun;

  // Top character bit is dropped in the narrow mode.
  generate
    if (CHAR_W > 1) begin : g_mask
      assign char_mask = {mode8, {(CHAR_W-1){1'b1}}};
    end else begin : g_mask1
      assign char_mask = mode8;
    end
  endgenerate

  assign char_in = rx_char & char_mask;
  assign overrun = done_q && !rd_hit;

  always_comb begin
    brk_word          = '0;
    brk_word[ERR_BIT] = 1'b1;
    brk_word[FRM_BIT] = 1'b1;
    brk_word[BRK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (rx_break) begin
      buf_q <= brk_word;
    end else if (rx_valid) begin
      buf_q              <= {{FLG_W{1'b0}}, char_in};
      buf_q[ERR_BIT]     <= overrun;
      buf_q[OVR_BIT]     <= overrun;
    end else if (rd_hit) begin
      buf_q[DATA_W-1:CHAR_W] <= '0;
    end
  end
endmodule

// File: rtl/rxc_rdport.sv
module rxc_rdport #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              sel,
  input  logic [DATA_W-1:0] buf_q,
  input  logic              done_q,
  input  logic              ie_q,
  output logic [DATA_W-1:0] rd_data_q
);
  import rxc_pkg::*;
  localparam int DONE_BIT = CHAR_W - 1;
  localparam int IE_BIT   = CHAR_W - 2;

  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[DONE_BIT] = done_q;
    stat_word[IE_BIT]   = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data_q <= '0;
    else if (rd_stb) rd_data_q <= (sel == REG_DATA) ? buf_q : stat_word;
  end
endmodule

// File: rtl/rx_console_regs.sv
module rx_console_regs #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_break,
  input  logic              halt_en,
  input  logic              mode8,
  output logic              irq,
  output logic              halt_req
);
  import rxc_pkg::*;
  localparam int IE_BIT = CHAR_W - 2;

  logic wr_stat, rd_hit, rx_evt;
  logic done_q, ie_q, irq_q, halt_q;
  logic [DATA_W-1:0] buf_q;

  assign wr_stat = wr_en && (sel == REG_STAT);
  assign rd_hit  = rd_stb && (sel == REG_DATA);
  assign rx_evt  = rx_valid || rx_break;

  rxc_status #(.CHAR_W(CHAR_W)) u_stat (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wr_ie(wr_data[IE_BIT]),
    .rd_hit(rd_hit), .rx_evt(rx_evt),
    .done_q(done_q), .ie_q(ie_q), .irq_q(irq_q)
  );

  rxc_buffer #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_buf (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_char(rx_char), .mode8(mode8), .done_q(done_q), .rd_hit(rd_hit),
    .buf_q(buf_q)
  );

  rxc_rdport #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .sel(sel), .buf_q(buf_q),
    .done_q(done_q), .ie_q(ie_q), .rd_data_q(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else     halt_q <= rx_break && halt_en;
  end

  assign irq      = irq_q;
  assign halt_req = halt_q;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_valid,
  input logic              rx_break,
  input logic              halt_en,
  input logic              irq,
  input logic              halt_req,
  input logic              done_q,
  input logic              ie_q
);
  localparam int IE_BIT = CHAR_W - 2;
  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(3) << (CHAR_W - 2);

  // R3
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie_q && done_q));

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel && !rx_valid && !rx_break) |=> (!irq && !done_q));

  // R5
  ie_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel && !wr_data[IE_BIT]) |=> !irq);

  // R1
  status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !sel) |=> ((rd_data & ~STAT_MASK) == '0));

  // R7
  halt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(rx_break && halt_en));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq && !halt_req && rd_data == '0));
endmodule

bind rx_console_regs rxc_checker #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
  .rd_stb(rd_stb), .rd_data(rd_data), .rx_valid(rx_valid),
  .rx_break(rx_break), .halt_en(halt_en), .irq(irq), .halt_req(halt_req),
  .done_q(done_q), .ie_q(ie_q)
);

// File: tb/sim_rx_console_regs.sv
`timescale 1ns/1ps
module sim_rx_console_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        rx_break = 1'b0;
  logic        halt_en = 1'b0;
  logic        mode8 = 1'b1;
  logic        irq;
  logic        halt_req;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  rx_console_regs u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_break(rx_break), .halt_en(halt_en),
    .mode8(mode8), .irq(irq), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_char(input logic [7:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic push_break(output logic h);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0; h = halt_req;
  endtask

  task automatic rd_reg(input logic s, output logic [15:0] v);
    @(negedge clk); sel = s; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0; v = rd_data;
  endtask

  task automatic wr_reg(input logic s, input logic [15:0] v);
    @(negedge clk); sel = s; wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq", {15'b0, irq}, 16'h0);
    chk("R10 halt", {15'b0, halt_req}, 16'h0);
    chk("R10 rd_data", rd_data, 16'h0);
    rd_reg(1'b0, v); chk("R10 status", v, 16'h0);
    rd_reg(1'b1, v); chk("R10 data", v, 16'h0);

    // R3 R4 R8 R1 R2: sweep every code in both modes
    for (int m = 0; m < 2; m++) begin
      mode8 = m[0];
      for (int c = 0; c < 256; c++) begin
        logic ie;
        logic [15:0] ec;
        ie = c[1];
        wr_reg(1'b0, {9'b0, ie, 6'b0});
        push_char(c[7:0]);
        chk("R3 irq", {15'b0, irq}, {15'b0, ie});
        rd_reg(1'b0, v); chk("R1 status", v, {8'b0, 1'b1, ie, 6'b0});
        ec = m[0] ? 16'(c) : 16'(c & 8'h7F);
        rd_reg(1'b1, v); chk("R8 R2 data", v, ec);
        chk("R4 irq", {15'b0, irq}, 16'h0);
        rd_reg(1'b0, v); chk("R4 done", v, {8'b0, 1'b0, ie, 6'b0});
      end
    end
    mode8 = 1'b1;

    // R12 hold after reads without strobe
    @(negedge clk); v = rd_data;
    repeat (3) @(negedge clk);
    chk("R12 hold", rd_data, v);

    // R9 overrun and R4 scrub
    wr_reg(1'b0, 16'h0000);
    push_char(8'h41);
    push_char(8'hC2);
    rd_reg(1'b1, v); chk("R9 overrun", v, 16'hC0C2);
    push_char(8'h33);
    rd_reg(1'b1, v); chk("R9 clean", v, 16'h0033);

    // R6 R7 break with halt enabled
    halt_en = 1'b1;
    push_break(h); chk("R7 halt", {15'b0, h}, 16'h1);
    @(negedge clk); chk("R7 pulse", {15'b0, halt_req}, 16'h0);
    rd_reg(1'b0, v); chk("R6 done", v, 16'h0080);
    rd_reg(1'b1, v); chk("R6 data", v, 16'hA400);
    rd_reg(1'b1, v); chk("R4 scrub", v, 16'h0000);
    halt_en = 1'b0;
    push_break(h); chk("R7 gated", {15'b0, h}, 16'h0);
    rd_reg(1'b1, v); chk("R6 data2", v, 16'hA400);

    // R5 enable while done pending, then disable
    push_char(8'h55);
    chk("R5 no irq", {15'b0, irq}, 16'h0);
    wr_reg(1'b0, 16'hFFFF);
    chk("R5 raise", {15'b0, irq}, 16'h1);
    rd_reg(1'b0, v); chk("R1 all-ones write", v, 16'h00C0);
    wr_reg(1'b0, 16'hFFBF);
    chk("R5 clear", {15'b0, irq}, 16'h0);
    rd_reg(1'b0, v); chk("R5 done kept", v, 16'h0080);

    // R11 data register write ignored
    wr_reg(1'b1, 16'hFFFF);
    rd_reg(1'b0, v); chk("R11 status", v, 16'h0080);
    rd_reg(1'b1, v); chk("R11 data", v, 16'h0055);

    // R10 reset with state pending
    wr_reg(1'b0, 16'h0040);
    push_char(8'h7E);
    chk("R3 irq pre-reset", {15'b0, irq}, 16'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 irq2", {15'b0, irq}, 16'h0);
    rd_reg(1'b0, v); chk("R10 status2", v, 16'h0);
    rd_reg(1'b1, v); chk("R10 data2", v, 16'h0);

    finish_run();
  end
endmodule